// File: doc/BRIEF.md
# Per-Hart Debug Flag Store

This block is the small shared memory region through which the debug module steers harts that sit in the debug idle loop. Each hart owns one flag byte in a contiguous window. A hart finds its byte at the window base plus its hart ID, so any number of harts can poll at once without contention. Bit 0 of the byte tells the hart to start an abstract command. Bit 1 tells it to leave debug mode. A hart checks the start bit before the leave bit.

The run-control side raises per-hart start and leave requests. Harts report back by storing their own hart ID, as a full word, to one of two fixed acknowledge addresses. A store to the start-acknowledge address clears the start bit of the hart named in the data. A store to the leave-acknowledge address clears that hart's leave bit and raises its leave acknowledge. A hart that sleeps between polls is woken by a one-cycle pulse whenever its byte changes.

Top module: `dbgflag_store`

## Requirements
- R1: A load (bus_valid=1, bus_we=0) at FLAGS_BASE+h, with h below NUM_HARTS, returns on bus_rdata, one cycle later with bus_rvalid=1, hart h's byte: bit 0 is the start bit, bit 1 is the leave bit, and bits 31:2 are zero. A load at any other address returns 0.
- R2: go_set[h]=1 sets hart h's start bit at the next clock edge.
- R3: A store with bus_size=2 (word) to GOING_ADDR whose data equals h clears the start bit of hart h and of no other hart.
- R4: A store to GOING_ADDR or RESUMING_ADDR with bus_size other than 2 (0=byte, 1=half, 3=double) raises bus_err for exactly the following cycle and changes no flag or acknowledge.
- R5: resume_set[h]=1 sets hart h's leave bit and drops resume_ack[h] to 0 at the same clock edge.
- R6: A word store to RESUMING_ADDR whose data equals h clears hart h's leave bit and sets resume_ack[h] to 1.
- R7: When a set request and a clear store target the same bit of the same hart in one cycle, the bit ends at 0. For the leave bit, resume_ack ends at 1.
- R8: wake[h] is 1 for exactly the cycle after an edge at which hart h's byte changed, and is 0 otherwise.
- R9: After reset, all flag bytes read 0, resume_ack is all ones, and wake and bus_err are 0.
- R10: A word store to either acknowledge address whose data is not below NUM_HARTS changes no byte and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Hart access strobe |
| bus_we | input | 1 | 1 for a store, 0 for a load |
| bus_addr | input | ADDR_W | Access address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| bus_wdata | input | 32 | Store data, which carries the hart ID |
| bus_rdata | output | 32 | Load data, registered |
| bus_rvalid | output | 1 | Load data valid, one cycle after the load |
| bus_err | output | 1 | Pulse for a store of the wrong size to an acknowledge address |
| go_set | input | NUM_HARTS | Per-hart start request |
| resume_set | input | NUM_HARTS | Per-hart leave request |
| resume_ack | output | NUM_HARTS | Per-hart leave acknowledge |
| wake | output | NUM_HARTS | Per-hart wake pulse |

## Verification
A set request from run control and an acknowledge store from a hart can land on the same bit in the same cycle. The bench provokes this in two places. It raises go_set for two harts while one of them stores its ID to the start-acknowledge address. It also raises resume_set for a hart in the same cycle that the hart stores to the leave-acknowledge address. The reference model resolves each such collision with the clear taking effect. A later load of the flag byte then confirms the bit is 0, and resume_ack, wake and bus_err are compared against the model in the cycle after the collision.

// File: rtl/dbgflag_pkg.sv
package dbgflag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Packed so that go lands on bit 0 and resume on bit 1.
    typedef struct packed {
        logic resume;
        logic go;
    } flag_t;

    function automatic logic [31:0] flag_word(flag_t f);
        return {30'b0, f};
    endfunction

endpackage

// File: rtl/dbgflag_decode.sv
module dbgflag_decode
    import dbgflag_pkg::*;
#(
    parameter int NUM_HARTS     = 4,
    parameter int ADDR_W        = 12,
    parameter int FLAGS_BASE    = 'h400,
    parameter int GOING_ADDR    = 'h100,
    parameter int RESUMING_ADDR = 'h108,
    localparam int ID_W         = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [NUM_HARTS-1:0] go_clr,
    output logic [NUM_HARTS-1:0] resume_clr,
    output logic                 rd_any,
    output logic                 rd_hit,
    output logic [ID_W-1:0]      rd_idx,
    output logic                 err
);

    logic              store, at_going, at_resuming, is_word, bad_size;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        store       = bus_valid && bus_we;
        at_going    = store && (bus_addr == ADDR_W'(GOING_ADDR));
        at_resuming = store && (bus_addr == ADDR_W'(RESUMING_ADDR));
        is_word     = (acc_size_e'(bus_size) == SZ_WORD);
        bad_size    = (at_going || at_resuming) && !is_word;
        offset      = bus_addr - ADDR_W'(FLAGS_BASE);
        rd_any      = bus_valid && !bus_we;
        rd_hit      = rd_any && (offset < ADDR_W'(NUM_HARTS));
        rd_idx      = offset[ID_W-1:0];
    end

    // One hart-ID comparator per hart: data outside 0..NUM_HARTS-1 hits none.
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_id
        logic id_match;
        assign id_match      = (bus_wdata == 32'(h));
        assign go_clr[h]     = at_going    && is_word && id_match;
        assign resume_clr[h] = at_resuming && is_word && id_match;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= bad_size;
    end

    // R4: a wrong-size acknowledge store is reported in the next cycle
    p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_size != 2'd2 &&
         (bus_addr == ADDR_W'(GOING_ADDR) || bus_addr == ADDR_W'(RESUMING_ADDR)))
        |=> err);

    // R3: a single store names at most one hart
    p_one_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_clr) && $onehot0(resume_clr));

endmodule

// File: rtl/dbgflag_cell.sv
module dbgflag_cell
    import dbgflag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go_set,
    input  logic  resume_set,
    input  logic  go_clr,
    input  logic  resume_clr,
    output flag_t flag,
    output logic  ack,
    output logic  wake
);

    flag_t nxt;
    logic  ack_nxt;

    always_comb begin
        nxt.go     = (flag.go     || go_set)     && !go_clr;
        nxt.resume = (flag.resume || resume_set) && !resume_clr;
        ack_nxt    = ack;
        if (resume_clr)      ack_nxt = 1'b1;
        else if (resume_set) ack_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            ack  <= 1'b1;
            wake <= 1'b0;
        end else begin
            flag <= nxt;
            ack  <= ack_nxt;
            wake <= (nxt != flag);
        end
    end

    // R7: clear beats set on the start bit
    p_go_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        go_clr |=> !flag.go);

    // R5: a lone resume request raises the bit and drops the acknowledge
    p_resume_req_r5: assert property (@(posedge clk) disable iff (rst)
        (resume_set && !resume_clr) |=> (flag.resume && !ack));

    // R6: resuming store lowers the bit and raises the acknowledge
    p_resume_ack_r6: assert property (@(posedge clk) disable iff (rst)
        resume_clr |=> (!flag.resume && ack));

    // R8: wake only follows a real change of the byte
    p_wake_change_r8: assert property (@(posedge clk) disable iff (rst)
        wake |-> (flag != $past(flag)));

endmodule

// File: rtl/dbgflag_rdport.sv
module dbgflag_rdport
    import dbgflag_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    localparam int ID_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  flag_t [NUM_HARTS-1:0] flags,
    input  logic                  rd_any,
    input  logic                  rd_hit,
    input  logic [ID_W-1:0]       rd_idx,
    output logic [31:0]           rdata,
    output logic                  rvalid
);

    logic [31:0] sel;

    always_comb begin
        sel = '0;
        for (int h = 0; h < NUM_HARTS; h++)
            if (rd_hit && rd_idx == ID_W'(h)) sel = flag_word(flags[h]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rdata  <= rd_any ? sel : '0;
            rvalid <= rd_any;
        end
    end

    // R1: every load is answered one cycle later
    p_load_answered_r1: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> rvalid);

    // R1: only the two flag bits can ever be nonzero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rdata[31:2] == '0);

endmodule

// File: rtl/dbgflag_store.sv
module dbgflag_store
    import dbgflag_pkg::*;
#(
    parameter int NUM_HARTS     = 4,
    parameter int ADDR_W        = 12,
    parameter int FLAGS_BASE    = 'h400,
    parameter int GOING_ADDR    = 'h100,
    parameter int RESUMING_ADDR = 'h108
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic                 bus_err,
    input  logic [NUM_HARTS-1:0] go_set,
    input  logic [NUM_HARTS-1:0] resume_set,
    output logic [NUM_HARTS-1:0] resume_ack,
    output logic [NUM_HARTS-1:0] wake
);

    localparam int ID_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    logic [NUM_HARTS-1:0]  go_clr, resume_clr;
    logic                  rd_any, rd_hit;
    logic [ID_W-1:0]       rd_idx;
    flag_t [NUM_HARTS-1:0] flags;

    dbgflag_decode #(
        .NUM_HARTS    (NUM_HARTS),
        .ADDR_W       (ADDR_W),
        .FLAGS_BASE   (FLAGS_BASE),
        .GOING_ADDR   (GOING_ADDR),
        .RESUMING_ADDR(RESUMING_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .go_clr    (go_clr),
        .resume_clr(resume_clr),
        .rd_any    (rd_any),
        .rd_hit    (rd_hit),
        .rd_idx    (rd_idx),
        .err       (bus_err)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        dbgflag_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .go_set    (go_set[h]),
            .resume_set(resume_set[h]),
            .go_clr    (go_clr[h]),
            .resume_clr(resume_clr[h]),
            .flag      (flags[h]),
            .ack       (resume_ack[h]),
            .wake      (wake[h])
        );
    end

    dbgflag_rdport #(
        .NUM_HARTS(NUM_HARTS)
    ) u_rdport (
        .clk   (clk),
        .rst   (rst),
        .flags (flags),
        .rd_any(rd_any),
        .rd_hit(rd_hit),
        .rd_idx(rd_idx),
        .rdata (bus_rdata),
        .rvalid(bus_rvalid)
    );

    // R4: an error pulse never lasts two cycles when the cause is gone
    p_err_single_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !(bus_valid && bus_we)) |=> !bus_err);

endmodule

// File: tb/tb_dbgflag_store.sv
`timescale 1ns/1ps
module tb_dbgflag_store;

    localparam int N     = 4;
    localparam int AW    = 12;
    localparam int BASE  = 'h400;
    localparam int GOING = 'h100;
    localparam int RESM  = 'h108;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, bus_err;
    logic [N-1:0]  go_set = '0, resume_set = '0;
    logic [N-1:0]  resume_ack, wake;

    always #10 clk = ~clk;

    dbgflag_store #(
        .NUM_HARTS(N), .ADDR_W(AW), .FLAGS_BASE(BASE),
        .GOING_ADDR(GOING), .RESUMING_ADDR(RESM)
    ) dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .go_set(go_set), .resume_set(resume_set),
        .resume_ack(resume_ack), .wake(wake)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd_q[$];
    logic [N-1:0] go_m = '0, res_m = '0, ack_m = '1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected load result per returned load.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (rd_q.size() == 0) chk("R1 unexpected load data", 32'h1, 32'h0);
            else chk("R1 load data", bus_rdata, rd_q.pop_front());
        end
    end

    // Driver: one cycle of stimulus, model update, then output checks.
    task automatic step(string req, logic v, logic we, int addr, logic [1:0] sz,
                        logic [31:0] data, logic [N-1:0] gs, logic [N-1:0] rs);
        logic         e_err;
        logic [N-1:0] gclr = '0, rclr = '0, ngo, nres, nack, e_wake;
        bus_valid = v; bus_we = we; bus_addr = AW'(addr); bus_size = sz;
        bus_wdata = data; go_set = gs; resume_set = rs;
        e_err = v && we && (addr == GOING || addr == RESM) && sz != 2'd2;
        for (int h = 0; h < N; h++) begin
            if (v && we && sz == 2'd2 && data == 32'(h)) begin
                if (addr == GOING) gclr[h] = 1'b1;
                if (addr == RESM)  rclr[h] = 1'b1;
            end
        end
        if (v && !we) begin
            if (addr >= BASE && addr < BASE + N)
                rd_q.push_back({30'b0, res_m[addr-BASE], go_m[addr-BASE]});
            else
                rd_q.push_back(32'h0);
        end
        ngo  = (go_m | gs) & ~gclr;
        nres = (res_m | rs) & ~rclr;
        nack = (ack_m & ~rs) | rclr;
        e_wake = (ngo ^ go_m) | (nres ^ res_m);
        go_m = ngo; res_m = nres; ack_m = nack;
        @(posedge clk);
        @(negedge clk);
        chk({req, " ack"},  32'(resume_ack), 32'(ack_m));
        chk({req, " wake"}, 32'(wake),       32'(e_wake));
        chk({req, " err"},  32'(bus_err),    32'(e_err));
        bus_valid = 1'b0; go_set = '0; resume_set = '0;
    endtask

    task automatic load(string req, int hart_or_addr);
        step(req, 1'b1, 1'b0, hart_or_addr, 2'd2, 32'h0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 ack after reset",  32'(resume_ack), 32'hF);
        chk("R9 wake after reset", 32'(wake), 32'h0);
        chk("R9 err after reset",  32'(bus_err), 32'h0);
        for (int h = 0; h < N; h++) load("R9 load", BASE + h);

        step("R2 go set hart1", 1'b0, 1'b0, 0, 2'd2, 0, 4'b0010, 4'b0000);
        load("R2 load", BASE + 1);
        // R7: hart1 set and cleared in one cycle, hart3 only set
        step("R7 go collision", 1'b1, 1'b1, GOING, 2'd2, 1, 4'b1010, 4'b0000);
        load("R7 load", BASE + 1);
        load("R7 load", BASE + 3);
        // R4 wrong size does nothing but flag an error
        step("R4 byte going", 1'b1, 1'b1, GOING, 2'd0, 3, '0, '0);
        step("R4 idle", 1'b0, 1'b0, 0, 2'd2, 0, '0, '0);
        load("R4 load", BASE + 3);
        // R5 / R6 resume handshake
        step("R5 resume hart2", 1'b0, 1'b0, 0, 2'd2, 0, '0, 4'b0100);
        load("R5 load", BASE + 2);
        step("R6 resuming store", 1'b1, 1'b1, RESM, 2'd2, 2, '0, '0);
        load("R6 load", BASE + 2);
        // R7: resume set and ack in one cycle
        step("R7 resume collision", 1'b1, 1'b1, RESM, 2'd2, 0, '0, 4'b0001);
        load("R7 load", BASE + 0);
        // R10 out-of-range IDs
        step("R10 going id7", 1'b1, 1'b1, GOING, 2'd2, 7, '0, '0);
        step("R10 resuming big id", 1'b1, 1'b1, RESM, 2'd2, 32'h1_0003, '0, '0);
        load("R10 load", BASE + 3);
        // R1 addresses outside the window
        load("R1 above window", BASE + N);
        load("R1 below window", BASE - 1);
        // R3 clear only the named hart
        step("R3 set hart0", 1'b0, 1'b0, 0, 2'd2, 0, 4'b0001, '0);
        step("R3 going hart3", 1'b1, 1'b1, GOING, 2'd2, 3, '0, '0);
        load("R3 load", BASE + 0);
        load("R3 load", BASE + 3);
        // R4 half store to resuming after a fresh resume request
        step("R4 resume hart1", 1'b0, 1'b0, 0, 2'd2, 0, '0, 4'b0010);
        step("R4 half resuming", 1'b1, 1'b1, RESM, 2'd1, 1, '0, '0);
        load("R4 load", BASE + 1);
        // R8 wake drops after a quiet cycle
        step("R8 quiet", 1'b0, 1'b0, 0, 2'd2, 0, '0, '0);
        step("R8 quiet", 1'b0, 1'b0, 0, 2'd2, 0, '0, '0);
        chk("R1 all loads answered", 32'(rd_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule